// File: doc/BRIEF.md
# Interrupt Pending State Merge

This block holds the interrupt-pending state of one hart as the CSR unit and the interrupt dispatcher see it. It covers four sources: machine external, machine software, supervisor external and supervisor software. The two machine bits are driven only by platform level lines from an interrupt generator. The supervisor software bit is a single flop. A CSR write and a generator strobe can each set or clear it.

The supervisor external bit has two parts: a software-writable latch and a platform level line. Reads and dispatch see the OR of the two. The old value handed to the CSR unit for a read-modify-write uses the latch alone, so a CSR update never turns the platform line into latched state. A supervisor-present input hides both supervisor bits while supervisor mode is absent. The platform line is still taken while supervisor mode is absent and shows up as soon as the mode is turned on. The CSR port offers a machine view and a supervisor view. A registered 4-bit pending vector feeds dispatch.

Top module: `ipend_merge`

## Requirements
- R1: In the machine view, bit 11 of the read data follows `plat_mei` and bit 3 follows `plat_msi` in the same cycle. A CSR write never changes them, and the read-modify-write old value carries the same two bits.
- R2: With supervisor mode present, bit 9 of the machine-view read data is the OR of the supervisor external latch and `plat_sei`. A machine-view write with `csr_wr_sei` loads the latch at the next clock edge.
- R3: Bit 9 of `csr_rmw_old` is the latch alone, so it reads 0 while only `plat_sei` is high.
- R4: Bit 1 (supervisor software) is one state bit. A CSR write in either view loads it from `csr_wr_ssi`, and reads show the new value after the next clock edge.
- R5: A generator strobe (`gen_ssi_we`) sets or clears bit 1 according to `gen_ssi_val`, effective after the next clock edge.
- R6: When a CSR write and a generator strobe arrive in the same cycle, the CSR write decides the new supervisor software value.
- R7: With `s_present` low, bits 1 and 9 read 0 on both read ports. Requests from either source to set bit 1 are ignored, and latch writes are ignored.
- R8: A `plat_sei` held high while supervisor mode is absent appears in bit 9 in the same cycle that `s_present` rises.
- R9: In the supervisor view (`csr_view_s`=1), only bits 1 and 9 can be nonzero. A write in this view changes only bit 1 and never the latch.
- R10: `irq_pend` holds bit0 supervisor software, bit1 machine software, bit2 supervisor external, bit3 machine external. It uses the merged, visible values and is registered, so it lags its sources by one clock.
- R11: After reset the supervisor software bit, the latch and `irq_pend` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_present | input | 1 | Supervisor mode enabled |
| plat_mei | input | 1 | Platform machine external level |
| plat_msi | input | 1 | Platform machine software level |
| plat_sei | input | 1 | Platform supervisor external level |
| gen_ssi_we | input | 1 | Generator strobe for supervisor software bit |
| gen_ssi_val | input | 1 | Value for the generator strobe (1 set, 0 clear) |
| csr_view_s | input | 1 | 0 machine view, 1 supervisor view |
| csr_we | input | 1 | CSR write strobe |
| csr_wr_ssi | input | 1 | New supervisor software value |
| csr_wr_sei | input | 1 | New supervisor external latch value (machine view only) |
| csr_rdata | output | XLEN | Read value, merged |
| csr_rmw_old | output | XLEN | Old value for read-modify-write, latch-only bit 9 |
| irq_pend | output | 4 | Registered pending vector for dispatch |

## Verification
The bench goes after the split between the read value and the read-modify-write old value. A design that merged the platform line into the old value would leave bit 9 of `csr_rmw_old` high after the latch is cleared. It drives same-cycle collisions of a strobe and a CSR write. A priority mix-up shows up there as the strobe's value surviving. It toggles `s_present` with `plat_sei` held high and with set requests pending. A design that dropped the platform level while hidden would fail to show bit 9 on enable, and one that honoured hidden set requests would show bit 1 afterwards. It also checks the one-cycle lag of `irq_pend`, which catches a combinational dispatch path or a lag of two stages.

// File: rtl/ipend_pkg.sv
// Shared constants and types for the interrupt pending merge block.
// Assumes the standard pending-bit positions within an XLEN-wide word.
package ipend_pkg;
    localparam int unsigned SSI_POS = 1;
    localparam int unsigned MSI_POS = 3;
    localparam int unsigned SEI_POS = 9;
    localparam int unsigned MEI_POS = 11;
    localparam int unsigned NUM_SRC = 4;

    // Dispatch order: the first field is the MSB (bit3).
    typedef struct packed {
        logic mei;
        logic sei;
        logic msi;
        logic ssi;
    } pend_t;
endpackage

// File: rtl/ipend_ssi_bit.sv
// Supervisor software pending bit: a single flop shared by CSR writes and
// generator strobes. CSR writes win a same-cycle collision. Set requests are
// ignored while supervisor mode is absent; clears are always honoured.
module ipend_ssi_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic s_present,
    input  logic csr_we,
    input  logic csr_val,
    input  logic gen_we,
    input  logic gen_val,
    output logic ssi_q
);
    logic ssi_d;

    // Next-state: generator first, CSR write overrides.
    always_comb begin
        ssi_d = ssi_q;
        if (gen_we) begin
            ssi_d = gen_val ? (s_present | ssi_q) : 1'b0;
        end
        if (csr_we) begin
            ssi_d = csr_val ? (s_present | ssi_q) : 1'b0;
        end
    end

    // State flop with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ssi_q <= 1'b0;
        else        ssi_q <= ssi_d;
    end

    AST_CSR_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && !csr_val) |=> !ssi_q); // R6
    AST_CSR_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_val && s_present) |=> ssi_q); // R4
    AST_GEN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_we && gen_val && !csr_we && s_present) |=> ssi_q); // R5
    AST_NO_SET_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_present && !ssi_q) |=> !ssi_q); // R7
endmodule

// File: rtl/ipend_sei_merge.sv
// Supervisor external pending: a software latch ORed with the platform level.
// Exposes the merged value and the latch-only value, both masked by
// supervisor presence. Latch writes are dropped while supervisor is absent.
module ipend_sei_merge (
    input  logic clk,
    input  logic rst_n,
    input  logic s_present,
    input  logic wr_en,
    input  logic wr_val,
    input  logic plat_sei,
    output logic sei_latch_vis,
    output logic sei_merged_vis
);
    logic latch_q;

    // Software latch, written only while supervisor mode exists.
    always_ff @(posedge clk) begin
        if (!rst_n)                  latch_q <= 1'b0;
        else if (wr_en && s_present) latch_q <= wr_val;
    end

    // Visible values: hidden entirely when supervisor mode is absent.
    always_comb begin
        sei_latch_vis  = latch_q & s_present;
        sei_merged_vis = (latch_q | plat_sei) & s_present;
    end

    AST_MERGE_COVERS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        sei_latch_vis |-> sei_merged_vis); // R2
    AST_LATCH_FROZEN_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        !s_present |=> (latch_q == $past(latch_q))); // R7
    AST_LATCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && s_present) |=> (sei_latch_vis == $past(wr_val) || !s_present)); // R2
endmodule

// File: rtl/ipend_dispatch_reg.sv
// Registered pending vector for the dispatcher, one flop per source.
// Assumes the sources are already merged and masked for visibility.
module ipend_dispatch_reg #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // One pipeline flop per pending source.
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= d[i];
        end
    end
endmodule

// File: rtl/ipend_merge.sv
// Top of the interrupt pending merge block. Builds the machine and
// supervisor views for CSR reads, the read-modify-write old value (latch-only
// supervisor external bit), and the registered dispatch vector.
// Assumes XLEN is at least 12 so that all pending positions exist.
module ipend_merge #(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            s_present,
    input  logic            plat_mei,
    input  logic            plat_msi,
    input  logic            plat_sei,
    input  logic            gen_ssi_we,
    input  logic            gen_ssi_val,
    input  logic            csr_view_s,
    input  logic            csr_we,
    input  logic            csr_wr_ssi,
    input  logic            csr_wr_sei,
    output logic [XLEN-1:0] csr_rdata,
    output logic [XLEN-1:0] csr_rmw_old,
    output logic [3:0]      irq_pend
);
    import ipend_pkg::*;

    localparam logic [XLEN-1:0] S_MASK =
        (XLEN'(1) << SSI_POS) | (XLEN'(1) << SEI_POS);

    logic  ssi_q;
    logic  ssi_vis;
    logic  sei_latch_vis;
    logic  sei_merged_vis;
    pend_t pend_now;
    logic [XLEN-1:0] m_read;
    logic [XLEN-1:0] m_rmw;

    ipend_ssi_bit u_ssi (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_present (s_present),
        .csr_we    (csr_we),
        .csr_val   (csr_wr_ssi),
        .gen_we    (gen_ssi_we),
        .gen_val   (gen_ssi_val),
        .ssi_q     (ssi_q)
    );

    ipend_sei_merge u_sei (
        .clk            (clk),
        .rst_n          (rst_n),
        .s_present      (s_present),
        .wr_en          (csr_we && !csr_view_s),
        .wr_val         (csr_wr_sei),
        .plat_sei       (plat_sei),
        .sei_latch_vis  (sei_latch_vis),
        .sei_merged_vis (sei_merged_vis)
    );

    // Visible source set, in dispatch order.
    always_comb begin
        ssi_vis      = ssi_q & s_present;
        pend_now.ssi = ssi_vis;
        pend_now.msi = plat_msi;
        pend_now.sei = sei_merged_vis;
        pend_now.mei = plat_mei;
    end

    // Machine-view words: merged for reads, latch-only SEI for RMW.
    always_comb begin
        m_read          = '0;
        m_read[SSI_POS] = ssi_vis;
        m_read[MSI_POS] = plat_msi;
        m_read[SEI_POS] = sei_merged_vis;
        m_read[MEI_POS] = plat_mei;
        m_rmw           = m_read;
        m_rmw[SEI_POS]  = sei_latch_vis;
    end

    // View select: the supervisor view keeps only supervisor positions.
    always_comb begin
        csr_rdata   = csr_view_s ? (m_read & S_MASK) : m_read;
        csr_rmw_old = csr_view_s ? (m_rmw & S_MASK)  : m_rmw;
    end

    ipend_dispatch_reg #(.WIDTH(NUM_SRC)) u_disp (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pend_now),
        .q     (irq_pend)
    );

    AST_MACH_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_view_s |-> (csr_rdata[MEI_POS] == plat_mei && csr_rmw_old[MSI_POS] == plat_msi)); // R1
    AST_RMW_LATCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_view_s && s_present) |-> (csr_rdata[SEI_POS] == (csr_rmw_old[SEI_POS] | plat_sei))); // R3
    AST_S_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        !s_present |-> (!csr_rdata[SSI_POS] && !csr_rdata[SEI_POS] && !csr_rmw_old[SEI_POS])); // R7
    AST_SEI_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (s_present && plat_sei) |-> csr_rdata[SEI_POS]); // R8
    AST_SVIEW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        csr_view_s |-> ((csr_rdata & ~S_MASK) == '0)); // R9
    AST_DISPATCH_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_view_s |=> (irq_pend == {$past(csr_rdata[MEI_POS]), $past(csr_rdata[SEI_POS]),
                                      $past(csr_rdata[MSI_POS]), $past(csr_rdata[SSI_POS])})); // R10
endmodule

// File: tb/tb_ipend_merge.sv
// Directed bench for ipend_merge: one task per scenario, each checking itself.
module tb_ipend_merge;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst_n, s_present, plat_mei, plat_msi, plat_sei;
    logic gen_ssi_we, gen_ssi_val, csr_view_s, csr_we, csr_wr_ssi, csr_wr_sei;
    logic [XLEN-1:0] csr_rdata, csr_rmw_old;
    logic [3:0] irq_pend;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ipend_merge #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .s_present(s_present),
        .plat_mei(plat_mei), .plat_msi(plat_msi), .plat_sei(plat_sei),
        .gen_ssi_we(gen_ssi_we), .gen_ssi_val(gen_ssi_val),
        .csr_view_s(csr_view_s), .csr_we(csr_we),
        .csr_wr_ssi(csr_wr_ssi), .csr_wr_sei(csr_wr_sei),
        .csr_rdata(csr_rdata), .csr_rmw_old(csr_rmw_old), .irq_pend(irq_pend)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Select a view and let the combinational read settle.
    task automatic view(input logic s);
        csr_view_s = s;
        #1;
    endtask

    // One-cycle CSR write; returns at the next falling edge.
    task automatic csr_write(input logic s, input logic ssi, input logic sei);
        @(negedge clk);
        csr_view_s = s; csr_we = 1'b1; csr_wr_ssi = ssi; csr_wr_sei = sei;
        @(negedge clk);
        csr_we = 1'b0; csr_wr_ssi = 1'b0; csr_wr_sei = 1'b0;
        #1;
    endtask

    task automatic gen_strobe(input logic v);
        @(negedge clk);
        gen_ssi_we = 1'b1; gen_ssi_val = v;
        @(negedge clk);
        gen_ssi_we = 1'b0; gen_ssi_val = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        view(1'b0);
        chk("R11 read after reset", csr_rdata, 32'h0);
        chk("R11 rmw after reset", csr_rmw_old, 32'h0);
        chk("R11 dispatch after reset", {28'h0, irq_pend}, 32'h0);
    endtask

    task automatic t_machine_lines;
        @(negedge clk); plat_mei = 1'b1; view(1'b0);
        chk("R1 mei bit11", csr_rdata, 32'h800);
        csr_write(1'b0, 1'b0, 1'b0);
        view(1'b0);
        chk("R1 write leaves mei", csr_rdata, 32'h800);
        chk("R1 rmw mei", csr_rmw_old, 32'h800);
        @(negedge clk); plat_mei = 1'b0; plat_msi = 1'b1; view(1'b0);
        chk("R1 msi bit3", csr_rdata, 32'h008);
        @(negedge clk); plat_msi = 1'b0;
    endtask

    task automatic t_sei_merge;
        csr_write(1'b0, 1'b0, 1'b1);
        view(1'b0);
        chk("R2 latch read", csr_rdata, 32'h200);
        chk("R3 latch in rmw", csr_rmw_old, 32'h200);
        @(negedge clk); plat_sei = 1'b1;
        csr_write(1'b0, 1'b0, 1'b0);
        view(1'b0);
        chk("R2 platform only read", csr_rdata, 32'h200);
        chk("R3 rmw excludes platform", csr_rmw_old, 32'h0);
        @(negedge clk); plat_sei = 1'b0; view(1'b0);
        chk("R2 both clear", csr_rdata, 32'h0);
    endtask

    task automatic t_ssi_csr;
        csr_write(1'b1, 1'b1, 1'b0);
        view(1'b1);
        chk("R4 set via s view", csr_rdata, 32'h2);
        view(1'b0);
        chk("R4 seen in m view", csr_rdata, 32'h2);
        csr_write(1'b0, 1'b0, 1'b0);
        view(1'b0);
        chk("R4 clear via m view", csr_rdata, 32'h0);
        csr_write(1'b1, 1'b0, 1'b1);
        view(1'b0);
        chk("R9 s view write skips latch", csr_rmw_old, 32'h0);
    endtask

    task automatic t_ssi_gen;
        gen_strobe(1'b1);
        view(1'b0);
        chk("R5 generator set", csr_rdata, 32'h2);
        gen_strobe(1'b0);
        chk("R5 generator clear", csr_rdata, 32'h0);
    endtask

    task automatic t_conflict;
        @(negedge clk);
        gen_ssi_we = 1'b1; gen_ssi_val = 1'b1;
        csr_view_s = 1'b0; csr_we = 1'b1; csr_wr_ssi = 1'b0;
        @(negedge clk);
        gen_ssi_we = 1'b0; gen_ssi_val = 1'b0; csr_we = 1'b0;
        #1;
        chk("R6 csr clear beats gen set", csr_rdata, 32'h0);
        @(negedge clk);
        gen_ssi_we = 1'b1; gen_ssi_val = 1'b0;
        csr_we = 1'b1; csr_wr_ssi = 1'b1;
        @(negedge clk);
        gen_ssi_we = 1'b0; csr_we = 1'b0; csr_wr_ssi = 1'b0;
        #1;
        chk("R6 csr set beats gen clear", csr_rdata, 32'h2);
        csr_write(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_absent;
        @(negedge clk); s_present = 1'b0; plat_sei = 1'b1; view(1'b0);
        chk("R7 sei hidden", csr_rdata, 32'h0);
        csr_write(1'b0, 1'b1, 1'b1);
        gen_strobe(1'b1);
        view(1'b0);
        chk("R7 sets ignored read", csr_rdata, 32'h0);
        @(negedge clk); s_present = 1'b1; view(1'b0);
        chk("R8 sei visible on enable", csr_rdata, 32'h200);
        chk("R7 latch write was ignored", csr_rmw_old, 32'h0);
        csr_write(1'b0, 1'b1, 1'b0);
        @(negedge clk); s_present = 1'b0; view(1'b1);
        chk("R7 ssi hidden in s view", csr_rdata, 32'h0);
        @(negedge clk); s_present = 1'b1; plat_sei = 1'b0;
        csr_write(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_sview;
        @(negedge clk); plat_mei = 1'b1; plat_msi = 1'b1; plat_sei = 1'b1;
        csr_write(1'b1, 1'b1, 1'b0);
        view(1'b1);
        chk("R9 s view mask", csr_rdata, 32'h202);
        view(1'b0);
        chk("R9 m view full", csr_rdata, 32'hA0A);
        @(negedge clk); plat_mei = 1'b0; plat_msi = 1'b0; plat_sei = 1'b0;
        csr_write(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_dispatch;
        @(negedge clk); view(1'b0);
        chk("R10 idle dispatch", {28'h0, irq_pend}, 32'h0);
        plat_mei = 1'b1; #1;
        chk("R10 lag before edge", {28'h0, irq_pend}, 32'h0);
        @(negedge clk); #1;
        chk("R10 mei bit3", {28'h0, irq_pend}, 32'h8);
        csr_write(1'b0, 1'b1, 1'b0);
        chk("R10 ssi not yet", {28'h0, irq_pend}, 32'h8);
        @(negedge clk); #1;
        chk("R10 ssi bit0", {28'h0, irq_pend}, 32'h9);
        plat_sei = 1'b1;
        @(negedge clk); #1;
        chk("R10 sei bit2", {28'h0, irq_pend}, 32'hD);
        plat_msi = 1'b1;
        @(negedge clk); #1;
        chk("R10 msi bit1", {28'h0, irq_pend}, 32'hF);
        plat_mei = 1'b0; plat_msi = 1'b0; plat_sei = 1'b0;
        csr_write(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; s_present = 1'b1;
        plat_mei = 1'b0; plat_msi = 1'b0; plat_sei = 1'b0;
        gen_ssi_we = 1'b0; gen_ssi_val = 1'b0;
        csr_view_s = 1'b0; csr_we = 1'b0; csr_wr_ssi = 1'b0; csr_wr_sei = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_machine_lines();
        t_sei_merge();
        t_ssi_csr();
        t_ssi_gen();
        t_conflict();
        t_absent();
        t_sview();
        t_dispatch();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule